// File: doc/BRIEF.md
# UART Transmitter with Line Status Timing

This block is the transmit side of a classic register-mapped UART. Software writes bytes into a holding store. The store is a single holding register, or a 16-entry queue when queue mode is on. The bytes are framed and sent on `tx`, and each bit lasts one baud period. A 16-bit divisor sets the baud period, counted in system clocks. Two line status flags track the data path. "Holding empty" is bit 5 of the status register. "Transmitter empty" is bit 6, and it is set only once the last frame has fully left. A transmit-empty interrupt request goes with the holding flag.

Bytes move from the store into the shift register at fixed baud-tick points. From rest, a byte is loaded 8 ticks after it arrives. While a frame is on the line, the next byte is taken into a staging slot once the frame has spent as many ticks as it has data bits. That byte then starts the instant the current frame's last stop bit ends.

The sequencer is a three-state machine:
- `S_IDLE`: nothing to send. `tx` is high.
- `S_DELAY`: counting 8 ticks before a load.
- `S_SHIFT`: a frame is on the line.

It has these transitions:
- IDLE→DELAY: the store becomes non-empty.
- DELAY→SHIFT: the 8th tick arrives. The store head is loaded.
- SHIFT→SHIFT: the frame ends and a byte is staged. That byte starts at once.
- SHIFT→DELAY: the frame ends with nothing staged, but the store holds a byte.
- SHIFT→IDLE: the frame ends with nothing left.
- Any state→IDLE: a transmit reset.

Register map:

| Address | Access | Register |
|---|---|---|
| 0 | write | holding register |
| 1 | read/write | interrupt enable |
| 2 | write | FIFO control |
| 3 | read/write | line control |
| 4 | read/write | divisor low byte |
| 5 | read | line status |
| 6 | read/write | divisor high byte |

Reads return data on the cycle after the `rd` strobe.

Top module: `uart_tx_status`

## Requirements
- R1: After reset the status register reads 0x60, the interrupt enable and line control registers read 0x00, queue mode is off, `tx` is high and `irq` is low.
- R2: A frame is sent as follows:
  - a low start bit;
  - LCR[1:0]+5 data bits, LSB first;
  - a parity bit when LCR[3]=1, making the count of ones even when LCR[4]=1 and odd when LCR[4]=0;
  - high stop bits, two when LCR[2]=1 and one otherwise.
  Each bit lasts one baud period.
- R3: A write to the holding register at address 0 clears status bits 5 and 6 and withdraws the transmit-empty interrupt.
- R4: From rest, the start bit of a written byte begins 8 baud ticks after the write.
- R5: When a byte is waiting while a frame is on the line, it is taken into staging after as many ticks into the frame as the frame has data bits. Its frame begins immediately after the current frame's stop bits, with no idle gap.
- R6: A byte written after the staging point of the current frame starts 8 ticks after that frame ends.
- R7: When a load empties the store, status bit 5 sets and an interrupt becomes pending. `irq` is high while it is pending and interrupt-enable bit 1 is set.
- R8: Status bit 6 sets when a frame ends with nothing staged and the store empty, and only while bit 5 is set.
- R9: FIFO control bit 0 selects a 16-entry queue, sent in write order. A write to a full store, whether the queue or the single holding register, is dropped.
- R10: A FIFO control write that changes bit 0 or bit 2 empties the store, abandons any frame, returns `tx` high, sets status bits 5 and 6 and clears the pending interrupt.
- R11: The baud tick occurs once every N clocks, where N is the 16-bit divisor, and a divisor of 0 stops the tick. Writing either divisor byte restarts the tick count.
- R12: Status bits 0 to 4 always read zero, and reading the status register has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, data valid next cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| tx | output | 1 | Serial output, idles high |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
Assertions check on every cycle that:
- transmitter-empty never stands without holding-empty;
- a holding write leaves both flags and the interrupt clear;
- the queue never holds more than its depth, and a write to a full store leaves the occupancy unchanged;
- the last bit of every frame is high and every frame opens with a low start bit;
- a zero divisor yields no tick.

Only the bench scenarios can show the timing relations counted in baud ticks: the 8-tick start delay, the gapless back-to-back hand-off, the extra 8 ticks for a late write, and the data-bit staging point. The same holds for the decoded bit patterns under each line control setting, the order and count of queued bytes, and the effect of a transmit reset on a frame in progress.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int FRAME_W    = 12;
    localparam int REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] A_THR   = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_IER   = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_FCR   = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_LCR   = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_DIVLO = 3'd4;
    localparam logic [REG_ADDR_W-1:0] A_LSR   = 3'd5;
    localparam logic [REG_ADDR_W-1:0] A_DIVHI = 3'd6;

    typedef enum logic [1:0] {S_IDLE, S_DELAY, S_SHIFT} tx_state_t;

    function automatic logic [3:0] data_count(input logic [4:0] lc);
        return 4'(lc[1:0]) + 4'd5;
    endfunction

    function automatic logic [3:0] frame_len(input logic [4:0] lc);
        return data_count(lc) + 4'd2 + 4'(lc[2]) + 4'(lc[3]);
    endfunction

    // Bit 0 goes out first; unused upper positions stay high (stop level).
    function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] b, input logic [4:0] lc);
        logic [FRAME_W-1:0] f;
        logic [3:0]         dc;
        logic               par;
        f   = '1;
        f[0] = 1'b0;
        dc  = data_count(lc);
        par = ~lc[4];
        for (int i = 0; i < 8; i++) begin
            if (i < int'(dc)) begin
                f[1+i] = b[i];
                par    = par ^ b[i];
            end
        end
        if (lc[3]) f[4'd1 + dc] = par;
        return f;
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (restart || divisor == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor - DIV_W'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end

    p_zero_div_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0 && $past(divisor) == '0) |-> !tick);

endmodule

// File: rtl/uart_tx_store.sv
module uart_tx_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         fifo_mode,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         last
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count, cap;
    logic             full, do_push, do_pop;

    assign cap     = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
    assign full    = count >= cap;
    assign empty   = count == '0;
    assign last    = count == CNT_W'(1);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(count));
    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int START_DELAY = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       tick,
    input  logic [4:0] lcr,
    input  logic       src_empty,
    input  logic [7:0] src_data,
    output logic       src_pop,
    output logic       drained,
    output logic       tx
);
    localparam int DCNT_W = $clog2(START_DELAY + 1);

    tx_state_t          state, state_nx;
    logic [DCNT_W-1:0]  dcnt;
    logic [FRAME_W-1:0] sh;
    logic [3:0]         bit_idx, nbits, ndata;
    logic               staged_v;
    logic [7:0]         staged;
    logic               delay_done, end_frame;

    assign delay_done = (state == S_DELAY) && tick && dcnt == DCNT_W'(START_DELAY - 1);
    assign end_frame  = (state == S_SHIFT) && tick && bit_idx == nbits - 4'd1;
    assign src_pop    = !src_empty && (delay_done ||
                        ((state == S_SHIFT) && tick && !staged_v && bit_idx == ndata - 4'd1));
    assign drained    = end_frame && !staged_v && src_empty;
    assign tx         = (state == S_SHIFT) ? sh[0] : 1'b1;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (!src_empty) state_nx = S_DELAY;
            S_DELAY: if (delay_done) state_nx = src_empty ? S_IDLE : S_SHIFT;
            S_SHIFT: if (end_frame)
                         state_nx = staged_v ? S_SHIFT : (src_empty ? S_IDLE : S_DELAY);
            default: state_nx = S_IDLE;
        endcase
        if (abort) state_nx = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt <= '0; sh <= '1; bit_idx <= '0; nbits <= '0; ndata <= '0;
            staged_v <= 1'b0; staged <= '0;
        end else if (abort) begin
            dcnt <= '0; sh <= '1; bit_idx <= '0; staged_v <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: dcnt <= '0;
                S_DELAY: if (tick) begin
                    dcnt <= dcnt + DCNT_W'(1);
                    if (src_pop) begin
                        sh      <= build_frame(src_data, lcr);
                        nbits   <= frame_len(lcr);
                        ndata   <= data_count(lcr);
                        bit_idx <= '0;
                        dcnt    <= '0;
                    end
                end
                S_SHIFT: if (tick) begin
                    if (end_frame) begin
                        dcnt    <= '0;
                        bit_idx <= '0;
                        if (staged_v) begin
                            sh       <= build_frame(staged, lcr);
                            nbits    <= frame_len(lcr);
                            ndata    <= data_count(lcr);
                            staged_v <= 1'b0;
                        end else begin
                            sh <= '1;
                        end
                    end else begin
                        sh      <= {1'b1, sh[FRAME_W-1:1]};
                        bit_idx <= bit_idx + 4'd1;
                    end
                    if (src_pop) begin
                        staged   <= src_data;
                        staged_v <= 1'b1;
                    end
                end
                default: dcnt <= '0;
            endcase
        end
    end

    p_stop_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        end_frame |-> tx);
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_SHIFT && state_nx == S_SHIFT && !abort) |=> !tx);

endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int DIV_W       = 16,
    parameter int START_DELAY = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic                  tx,
    output logic                  irq
);
    logic [7:0]       ier, lcr;
    logic [DIV_W-1:0] divisor;
    logic             fifo_en, txrst_bit;
    logic             thre, temt, pend;
    logic             wr_thr, flush, div_wr, tick;
    logic             src_empty, src_last, src_pop, drained;
    logic [7:0]       src_data;

    assign wr_thr = wr && addr == A_THR;
    assign div_wr = wr && (addr == A_DIVLO || addr == A_DIVHI);
    assign flush  = wr && addr == A_FCR &&
                    ((wdata[0] ^ fifo_en) || (wdata[2] ^ txrst_bit));
    assign irq    = ier[1] && pend;

    uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .restart(div_wr), .divisor(divisor), .tick(tick));

    uart_tx_store #(.DEPTH(FIFO_DEPTH), .W(8)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fifo_mode(fifo_en),
        .push(wr_thr), .din(wdata), .pop(src_pop), .dout(src_data),
        .empty(src_empty), .last(src_last));

    uart_tx_shifter #(.START_DELAY(START_DELAY)) u_shift (
        .clk(clk), .rst_n(rst_n), .abort(flush), .tick(tick), .lcr(lcr[4:0]),
        .src_empty(src_empty), .src_data(src_data), .src_pop(src_pop),
        .drained(drained), .tx(tx));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier <= '0; lcr <= '0; divisor <= '0; fifo_en <= 1'b0; txrst_bit <= 1'b0;
        end else if (wr) begin
            unique case (addr)
                A_IER:   ier <= wdata;
                A_LCR:   lcr <= wdata;
                A_FCR:   begin fifo_en <= wdata[0]; txrst_bit <= wdata[2]; end
                A_DIVLO: divisor[7:0] <= wdata;
                A_DIVHI: divisor[DIV_W-1:8] <= wdata[DIV_W-9:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thre <= 1'b1; temt <= 1'b1; pend <= 1'b0;
        end else if (flush) begin
            thre <= 1'b1; temt <= 1'b1; pend <= 1'b0;
        end else if (wr_thr) begin
            thre <= 1'b0; temt <= 1'b0; pend <= 1'b0;
        end else begin
            if (src_pop && src_last) begin
                thre <= 1'b1;
                pend <= 1'b1;
            end
            if (drained && thre) temt <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else if (rd) begin
            unique case (addr)
                A_IER:   rdata <= ier;
                A_LCR:   rdata <= lcr;
                A_LSR:   rdata <= {1'b0, temt, thre, 5'b0};
                A_DIVLO: rdata <= divisor[7:0];
                A_DIVHI: rdata <= 8'(divisor[DIV_W-1:8]);
                default: rdata <= '0;
            endcase
        end
    end

    p_temt_needs_thre_r8: assert property (@(posedge clk) disable iff (!rst_n)
        temt |-> thre);
    p_write_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_thr |=> (!thre && !temt && !irq));

endmodule

// File: tb/tb_uart_tx_status.sv
module tb_uart_tx_status;
    localparam int CLK_PERIOD = 10;
    localparam int D          = 4;

    logic       clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tx, irq;
    int         errors = 0, checks = 0, cyc = 0;
    bit         done = 0;

    uart_tx_status dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd),
                        .wdata(wdata), .rdata(rdata), .tx(tx), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
    endtask

    task automatic wait_fall(output int t);
        int n = 0;
        while (tx !== 1'b0 && n < 4000) begin @(negedge clk); n++; end
        t = cyc;
    endtask

    task automatic recv_frame(input int nd, input bit pen, input bit even, input int nstop,
                              output logic [7:0] b, output int t, output bit ok);
        logic par;
        ok = 1; b = '0;
        wait_fall(t);
        if (tx !== 1'b0) begin ok = 0; return; end
        repeat (D/2) @(negedge clk);
        if (tx !== 1'b0) ok = 0;
        par = even ? 1'b0 : 1'b1;
        for (int i = 0; i < nd; i++) begin
            repeat (D) @(negedge clk); b[i] = tx; par = par ^ tx;
        end
        if (pen) begin repeat (D) @(negedge clk); if (tx !== par) ok = 0; end
        for (int s = 0; s < nstop; s++) begin
            repeat (D) @(negedge clk); if (tx !== 1'b1) ok = 0;
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        bus_read(3'd5, v); check(v == 8'h60, "R1/R12 LSR after reset", v, 8'h60);
        bus_read(3'd1, v); check(v == 8'h00, "R1 IER after reset", v, 0);
        bus_read(3'd3, v); check(v == 8'h00, "R1 LCR after reset", v, 0);
        check(tx === 1'b1 && irq === 1'b0, "R1 tx/irq after reset", {tx, irq}, 2'b10);
        bus_read(3'd5, v); check(v == 8'h60, "R12 LSR read has no side effect", v, 8'h60);
    endtask

    task automatic t_idle_start;
        logic [7:0] v, b; int tf, tw; bit ok;
        fork
            recv_frame(8, 0, 0, 1, b, tf, ok);
            begin
                bus_write(3'd0, 8'hA5); tw = cyc;
                bus_read(3'd5, v); check(v == 8'h00, "R3 LSR after write", v, 0);
                check(irq === 1'b0, "R3 irq withdrawn", irq, 0);
                while (tx !== 1'b0) @(negedge clk);
                bus_read(3'd5, v); check(v == 8'h20, "R7 bit5 set at load", v, 8'h20);
                check(irq === 1'b1, "R7 irq raised", irq, 1);
            end
        join
        check(ok && b == 8'hA5, "R2 8N1 frame", b, 8'hA5);
        check(tf - tw >= 7*D && tf - tw <= 9*D + 3, "R4 start delay", tf - tw, 8*D);
        repeat (D) @(negedge clk);
        bus_read(3'd5, v); check(v == 8'h60, "R8 bit6 after frame", v, 8'h60);
    endtask

    task automatic t_back2back;
        logic [7:0] v, b1, b2; int t1, t2, tb, tr; bit ok1, ok2;
        fork
            begin recv_frame(8, 0, 0, 1, b1, t1, ok1); recv_frame(8, 0, 0, 1, b2, t2, ok2); end
            begin
                bus_write(3'd0, 8'h3C);
                wait_fall(tb);
                bus_write(3'd0, 8'hC3);
                v = 8'h00; tr = 0;
                while (v[5] == 1'b0 && tr < 2000) begin bus_read(3'd5, v); tr++; end
                tr = cyc;
                check(tr - tb >= 8*D - 1 && tr - tb <= 8*D + 4, "R5 staging point", tr - tb, 8*D);
            end
        join
        check(ok1 && b1 == 8'h3C, "R5 first byte", b1, 8'h3C);
        check(ok2 && b2 == 8'hC3, "R5 second byte", b2, 8'hC3);
        check(t2 - t1 == 10*D, "R5 no gap", t2 - t1, 10*D);
        repeat (D) @(negedge clk);
    endtask

    task automatic t_late;
        logic [7:0] b1, b2; int t1, t2, tb; bit ok1, ok2;
        fork
            begin recv_frame(8, 0, 0, 1, b1, t1, ok1); recv_frame(8, 0, 0, 1, b2, t2, ok2); end
            begin
                bus_write(3'd0, 8'h81);
                wait_fall(tb);
                repeat (9*D - 1) @(negedge clk);
                bus_write(3'd0, 8'h7E);
            end
        join
        check(ok1 && ok2 && b2 == 8'h7E, "R6 late byte", b2, 8'h7E);
        check(t2 - t1 == 18*D, "R6 extra 8 ticks", t2 - t1, 18*D);
        repeat (D) @(negedge clk);
    endtask

    task automatic t_parity;
        logic [7:0] b; int t; bit ok;
        bus_write(3'd3, 8'h1E);
        fork recv_frame(7, 1, 1, 2, b, t, ok); bus_write(3'd0, 8'h5A); join
        check(ok && b[6:0] == 7'h5A, "R2 7E2 frame", b, 8'h5A);
        repeat (2*D) @(negedge clk);
        bus_write(3'd3, 8'h08);
        fork recv_frame(5, 1, 0, 1, b, t, ok); bus_write(3'd0, 8'h0C); join
        check(ok && b[4:0] == 5'h0C, "R2 5O1 frame", b, 8'h0C);
        repeat (2*D) @(negedge clk);
        bus_write(3'd3, 8'h03);
    endtask

    task automatic t_fifo;
        logic [7:0] v, b; int t, tp; bit ok, hi;
        bus_write(3'd4, 8'h00);
        bus_write(3'd0, 8'h11);
        hi = 1;
        repeat (30*D) begin @(negedge clk); if (tx !== 1'b1) hi = 0; end
        check(hi, "R11 zero divisor holds tx", hi, 1);
        bus_read(3'd5, v); check(v == 8'h00, "R11 byte still held", v, 0);
        bus_write(3'd2, 8'h01);
        bus_read(3'd5, v); check(v == 8'h60, "R10 mode change empties", v, 8'h60);
        for (int i = 0; i < 17; i++) bus_write(3'd0, 8'(i));
        bus_read(3'd5, v); check(v == 8'h00, "R9 queue loaded", v, 0);
        bus_write(3'd4, 8'(D));
        tp = 0;
        for (int i = 0; i < 16; i++) begin
            recv_frame(8, 0, 0, 1, b, t, ok);
            check(ok && b == 8'(i), "R9 queue order", b, i);
            if (i > 0) check(t - tp == 10*D, "R5 queue back-to-back", t - tp, 10*D);
            tp = t;
        end
        repeat (D) @(negedge clk);
        bus_read(3'd5, v); check(v == 8'h60, "R8 queue drained", v, 8'h60);
        hi = 1;
        repeat (20*D) begin @(negedge clk); if (tx !== 1'b1) hi = 0; end
        check(hi, "R9 17th byte dropped", hi, 1);
    endtask

    task automatic t_txreset;
        logic [7:0] v; int t; bit hi;
        for (int i = 0; i < 3; i++) bus_write(3'd0, 8'h55);
        wait_fall(t);
        bus_write(3'd2, 8'h05);
        bus_read(3'd5, v); check(v == 8'h60, "R10 reset sets bits 5 and 6", v, 8'h60);
        check(irq === 1'b0, "R10 pending cleared", irq, 0);
        hi = 1;
        repeat (30*D) begin @(negedge clk); if (tx !== 1'b1) hi = 0; end
        check(hi, "R10 frame abandoned", hi, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        bus_write(3'd4, 8'(D));
        bus_write(3'd6, 8'h00);
        bus_write(3'd3, 8'h03);
        bus_write(3'd1, 8'h02);
        t_idle_start();
        t_back2back();
        t_late();
        t_parity();
        t_fifo();
        t_txreset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule